// File: doc/BRIEF.md
# FPU status and control register

This block is the 32-bit status and control register of a floating-point unit. Software reads and writes it over a simple register port. It holds five mode settings: a register-bank swap, a paired (64-bit) transfer size, double precision, flush-denormals-to-zero and a two-bit rounding mode. The rest of the FPU takes these settings as decoded outputs. The block also flags when the paired-transfer and double-precision settings are both on, because that combination is reserved.

The register also holds three exception fields:

- **Cause** describes the most recent operation.
- **Enable** selects which exceptions trap.
- **Flag** keeps a sticky record of exceptions that did not trap.

Each time the datapath completes an operation, it reports six exception bits: unimplemented-operation error, invalid, divide-by-zero, overflow, underflow and inexact. The block replaces the cause field with that report. It raises a one-cycle trap request when the error bit is set, or when any reported exception has its enable bit set. If the operation traps, the flags are left untouched. Otherwise the reported bits are ORed into the flags.

Top module: `fpu_status_ctrl`

## Requirements
- R1: After reset the register reads 0x00040001 (flush-denormals set, rounding mode 1) and trap_req is low.
- R2: Bits 31:22 always read as zero; writing ones to them has no effect.
- R3: The mode outputs follow the register: bank_swap is bit 21, xfer_pair bit 20, dbl_prec bit 19, flush_denorm bit 18, round_mode bits 1:0.
- R4: mode_reserved is high exactly when bits 20 and 19 are both set.
- R5: A completed operation (op_done) overwrites the cause field with op_exc. op_exc[5] (error) goes to bit 17, [4] invalid to 16, [3] divide-by-zero to 15, [2] overflow to 14, [1] underflow to 13 and [0] inexact to 12.
- R6: If an operation does not trap, op_exc[4:0] is ORed into the flag field (invalid bit 6 down to inexact bit 2). Flags stay set until software writes them.
- R7: trap_req is high for the one cycle after an operation that reports the error bit, or that reports any of bits 4:0 whose enable bit is set. The enable bits are invalid bit 11 down to inexact bit 7. Otherwise trap_req is low.
- R8: An operation that traps leaves the flag field unchanged.
- R9: If a bus write and op_done arrive in the same cycle, the write takes effect and the operation is discarded: no cause update, no flag update and no trap.
- R10: bus_rd_data always shows the current register contents, and a write becomes visible after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Current register value |
| op_done | input | 1 | Datapath completed an operation this cycle |
| op_exc | input | 6 | Exception report {E,V,Z,O,U,I} |
| trap_req | output | 1 | One-cycle trap request |
| bank_swap | output | 1 | Register-bank swap mode |
| xfer_pair | output | 1 | 64-bit paired transfer mode |
| dbl_prec | output | 1 | Double-precision mode |
| flush_denorm | output | 1 | Treat denormal operands as zero |
| round_mode | output | 2 | Rounding mode |
| mode_reserved | output | 1 | Reserved size/precision combination selected |

## Verification
The bench covers the following corner cases:

- **Trapping operation.** It checks that the flags stay put and the new cause still appears. A design that always accumulated would leave the trapping exception in the flags.
- **Error bit with no enables.** The error bit must trap even though no enable bits are set. A design that only matched cause against enable would miss this trap.
- **Write and operation in the same cycle.** The written value must survive, and no trap may be raised. A design that gave the operation priority would corrupt the cause field.
- **Reserved bits and mode decode.** All-ones writes check that the reserved bits read zero. Separate checks cover the reserved-mode output, so that swapped mode bits or a half-decoded reserved combination show up at the ports.

// File: rtl/fpcsr_pkg.sv
// Package: field positions and widths of the FPU status/control register.
// Assumes a 32-bit register with the fixed layout used by the FPU decode.
package fpcsr_pkg;
    localparam int REG_W      = 32;
    localparam int NUM_EXC    = 5;            // V,Z,O,U,I
    localparam int CAUSE_W    = NUM_EXC + 1;  // plus E
    localparam int RM_W       = 2;
    localparam int RM_LSB     = 0;
    localparam int FLAG_LSB   = RM_LSB + RM_W;          // 2
    localparam int ENA_LSB    = FLAG_LSB + NUM_EXC;     // 7
    localparam int CAUSE_LSB  = ENA_LSB + NUM_EXC;      // 12
    localparam int DN_BIT     = CAUSE_LSB + CAUSE_W;    // 18
    localparam int PR_BIT     = DN_BIT + 1;             // 19
    localparam int SZ_BIT     = PR_BIT + 1;             // 20
    localparam int FR_BIT     = SZ_BIT + 1;             // 21
    localparam int USED_W     = FR_BIT + 1;             // 22
    localparam logic [REG_W-1:0] RESET_VAL = 32'h0004_0001;

    typedef logic [CAUSE_W-1:0] cause_t;
    typedef logic [NUM_EXC-1:0] exc_t;
endpackage

// File: rtl/fpcsr_mode_bits.sv
// Module: holds the mode settings (bank, size, precision, denormal, rounding)
// and decodes the reserved size+precision combination.
// Assumes a write strobe that, when high, loads all mode fields at once.
module fpcsr_mode_bits
    import fpcsr_pkg::*;
#(
    parameter int RM_WIDTH = RM_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic                fr_o,
    output logic                sz_o,
    output logic                pr_o,
    output logic                dn_o,
    output logic [RM_WIDTH-1:0] rm_o,
    output logic                rsvd_o
);
    logic                fr_q, sz_q, pr_q, dn_q;
    logic [RM_WIDTH-1:0] rm_q;

    // Load mode fields on a write, restore reset values on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q <= RESET_VAL[FR_BIT];
            sz_q <= RESET_VAL[SZ_BIT];
            pr_q <= RESET_VAL[PR_BIT];
            dn_q <= RESET_VAL[DN_BIT];
            rm_q <= RESET_VAL[RM_LSB +: RM_WIDTH];
        end else if (wr_en) begin
            fr_q <= wr_data[FR_BIT];
            sz_q <= wr_data[SZ_BIT];
            pr_q <= wr_data[PR_BIT];
            dn_q <= wr_data[DN_BIT];
            rm_q <= wr_data[RM_LSB +: RM_WIDTH];
        end
    end

    // Drive the decoded mode outputs.
    always_comb begin
        fr_o   = fr_q;
        sz_o   = sz_q;
        pr_o   = pr_q;
        dn_o   = dn_q;
        rm_o   = rm_q;
        rsvd_o = sz_q & pr_q;
    end

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rm_o == $past(wr_data[RM_LSB +: RM_WIDTH]) && dn_o == $past(wr_data[DN_BIT]))); // R3
    AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[SZ_BIT] && wr_data[PR_BIT]) |=> rsvd_o); // R4
endmodule

// File: rtl/fpcsr_exc_unit.sv
// Module: cause, enable and flag fields plus trap request generation.
// Assumes op_done is a single-cycle strobe per completed operation and that
// a bus write in the same cycle overrides the operation.
module fpcsr_exc_unit
    import fpcsr_pkg::*;
#(
    parameter int N_EXC = NUM_EXC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               op_done,
    input  logic [N_EXC:0]     op_exc,
    output logic [N_EXC:0]     cause_o,
    output logic [N_EXC-1:0]   enable_o,
    output logic [N_EXC-1:0]   flag_o,
    output logic               trap_o
);
    localparam int CW = N_EXC + 1;

    logic [CW-1:0]    cause_q;
    logic [N_EXC-1:0] enable_q, flag_q;
    logic             trap_q;
    logic             op_take, trap_hit;

    // Decide whether an operation is accepted and whether it traps.
    always_comb begin
        op_take  = op_done & ~wr_en;
        trap_hit = op_exc[N_EXC] | (|(op_exc[N_EXC-1:0] & enable_q));
    end

    // Update cause and enable fields from a write or an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q  <= RESET_VAL[CAUSE_LSB +: CW];
            enable_q <= RESET_VAL[ENA_LSB +: N_EXC];
        end else if (wr_en) begin
            cause_q  <= wr_data[CAUSE_LSB +: CW];
            enable_q <= wr_data[ENA_LSB +: N_EXC];
        end else if (op_take) begin
            cause_q  <= op_exc;
        end
    end

    // Accumulate sticky flags for non-trapping operations.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= RESET_VAL[FLAG_LSB +: N_EXC];
        else if (wr_en)
            flag_q <= wr_data[FLAG_LSB +: N_EXC];
        else if (op_take && !trap_hit)
            flag_q <= flag_q | op_exc[N_EXC-1:0];
    end

    // Register the one-cycle trap request.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= op_take & trap_hit;
    end

    assign cause_o  = cause_q;
    assign enable_o = enable_q;
    assign flag_o   = flag_q;
    assign trap_o   = trap_q;

    AST_CAUSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !wr_en) |=> cause_o == $past(op_exc)); // R5
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !op_done) |=> $stable(flag_o)); // R6
    AST_TRAP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> ($past(op_done) && !$past(wr_en))); // R7
    AST_ERR_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !wr_en && op_exc[N_EXC]) |=> (trap_o && $stable(flag_o))); // R8
    AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!trap_o && cause_o == $past(wr_data[CAUSE_LSB +: CW]))); // R9
endmodule

// File: rtl/fpu_status_ctrl.sv
// Module: top of the FPU status/control register. Assembles the read value,
// routes writes to the mode and exception units, exports decoded modes.
// Assumes a synchronous active-low reset and a single-cycle write strobe.
module fpu_status_ctrl
    import fpcsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_en,
    input  logic [REG_W-1:0]    bus_wr_data,
    output logic [REG_W-1:0]    bus_rd_data,
    input  logic                op_done,
    input  logic [CAUSE_W-1:0]  op_exc,
    output logic                trap_req,
    output logic                bank_swap,
    output logic                xfer_pair,
    output logic                dbl_prec,
    output logic                flush_denorm,
    output logic [RM_W-1:0]     round_mode,
    output logic                mode_reserved
);
    cause_t cause_w;
    exc_t   enable_w, flag_w;

    fpcsr_mode_bits #(.RM_WIDTH(RM_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_en),
        .wr_data (bus_wr_data),
        .fr_o    (bank_swap),
        .sz_o    (xfer_pair),
        .pr_o    (dbl_prec),
        .dn_o    (flush_denorm),
        .rm_o    (round_mode),
        .rsvd_o  (mode_reserved)
    );

    fpcsr_exc_unit #(.N_EXC(NUM_EXC)) u_exc (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_en),
        .wr_data  (bus_wr_data),
        .op_done  (op_done),
        .op_exc   (op_exc),
        .cause_o  (cause_w),
        .enable_o (enable_w),
        .flag_o   (flag_w),
        .trap_o   (trap_req)
    );

    // Assemble the read value; unused upper bits are constant zero.
    always_comb begin
        bus_rd_data = '0;
        bus_rd_data[FR_BIT]                 = bank_swap;
        bus_rd_data[SZ_BIT]                 = xfer_pair;
        bus_rd_data[PR_BIT]                 = dbl_prec;
        bus_rd_data[DN_BIT]                 = flush_denorm;
        bus_rd_data[CAUSE_LSB +: CAUSE_W]   = cause_w;
        bus_rd_data[ENA_LSB +: NUM_EXC]     = enable_w;
        bus_rd_data[FLAG_LSB +: NUM_EXC]    = flag_w;
        bus_rd_data[RM_LSB +: RM_W]         = round_mode;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_data[REG_W-1:USED_W] == '0); // R2
    AST_WR_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_en |=> bus_rd_data == ($past(bus_wr_data) & {{(REG_W-USED_W){1'b0}}, {USED_W{1'b1}}})); // R10
endmodule

// File: tb/fpu_status_ctrl_test.sv
module fpu_status_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr_en;
    logic [31:0] bus_wr_data;
    logic [31:0] bus_rd_data;
    logic        op_done;
    logic [5:0]  op_exc;
    logic        trap_req, bank_swap, xfer_pair, dbl_prec, flush_denorm, mode_reserved;
    logic [1:0]  round_mode;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fpu_status_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
        .bus_rd_data(bus_rd_data), .op_done(op_done), .op_exc(op_exc),
        .trap_req(trap_req), .bank_swap(bank_swap), .xfer_pair(xfer_pair),
        .dbl_prec(dbl_prec), .flush_denorm(flush_denorm), .round_mode(round_mode),
        .mode_reserved(mode_reserved)
    );

    // kind: 0 write, 1 operation, 2 write and operation together
    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] data;
        logic [5:0]  exc;
        logic [31:0] exp_rd;
        logic        exp_trap;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'hFFFF_FFFF, 6'h00, 32'h003F_FFFF, 1'b0}, // R2 R10
        '{2'd0, 32'h0000_0000, 6'h00, 32'h0000_0000, 1'b0}, // R10
        '{2'd0, 32'h0000_0800, 6'h00, 32'h0000_0800, 1'b0}, // enable V
        '{2'd1, 32'h0,         6'h01, 32'h0000_1804, 1'b0}, // R5 R6 inexact
        '{2'd1, 32'h0,         6'h06, 32'h0000_681C, 1'b0}, // R5 R6 O|U sticky
        '{2'd1, 32'h0,         6'h00, 32'h0000_081C, 1'b0}, // R5 cause cleared
        '{2'd1, 32'h0,         6'h10, 32'h0001_081C, 1'b1}, // R7 R8 enabled V
        '{2'd1, 32'h0,         6'h20, 32'h0002_081C, 1'b1}, // R7 R8 error
        '{2'd2, 32'h0000_0003, 6'h10, 32'h0000_0003, 1'b0}, // R9
        '{2'd0, 32'h0018_0000, 6'h00, 32'h0018_0000, 1'b0}  // R4 setup
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle();
        bus_wr_en = 1'b0; op_done = 1'b0; op_exc = '0; bus_wr_data = '0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        idle();
        step(); step();
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 reset value", bus_rd_data, 32'h0004_0001);
        check("R1 trap low", {31'd0, trap_req}, 32'd0);
        check("R3 reset decode", {26'd0, bank_swap, xfer_pair, dbl_prec, flush_denorm, round_mode},
              32'b000101);

        // vector table
        for (int i = 0; i < NV; i++) begin
            bus_wr_en   = (VECS[i].kind != 2'd1);
            op_done     = (VECS[i].kind != 2'd0);
            bus_wr_data = VECS[i].data;
            op_exc      = VECS[i].exc;
            step();
            check($sformatf("R5-R10 vector %0d rd", i), bus_rd_data, VECS[i].exp_rd);
            check($sformatf("R7 vector %0d trap", i), {31'd0, trap_req}, {31'd0, VECS[i].exp_trap});
            idle();
        end

        // R4 reserved combination after last vector
        check("R4 reserved both", {31'd0, mode_reserved}, 32'd1);

        // R7 trap is one cycle only
        bus_wr_en = 1'b1; bus_wr_data = 32'h0000_0080; step(); idle(); // enable I only
        op_done = 1'b1; op_exc = 6'h01; step(); idle();
        check("R7 enabled I traps", {31'd0, trap_req}, 32'd1);
        check("R8 flags untouched", bus_rd_data, 32'h0000_1080);
        step();
        check("R7 trap one cycle", {31'd0, trap_req}, 32'd0);
        check("R6 sticky idle", bus_rd_data, 32'h0000_1080);

        // R7 disabled exception does not trap; R6 accumulates
        op_done = 1'b1; op_exc = 6'h08; step(); idle();
        check("R7 disabled Z no trap", {31'd0, trap_req}, 32'd0);
        check("R6 Z flag set", bus_rd_data, 32'h0000_80A0);

        // R3 R4 decode of single bits, R2 reserved write ignored
        bus_wr_en = 1'b1; bus_wr_data = 32'hFFE0_0000 | 32'h0024_0002; step(); idle();
        check("R3 decode", {26'd0, bank_swap, xfer_pair, dbl_prec, flush_denorm, round_mode},
              32'b100110);
        check("R4 not reserved", {31'd0, mode_reserved}, 32'd0);
        check("R2 upper zero", bus_rd_data, 32'h0024_0002);

        bus_wr_en = 1'b1; bus_wr_data = 32'h0010_0000; step(); idle();
        check("R4 size only", {31'd0, mode_reserved}, 32'd0);

        // R1 reset again restores value
        bus_wr_en = 1'b1; bus_wr_data = 32'h003F_FFFF; step(); idle();
        rst_n = 1'b0; step(); rst_n = 1'b1;
        check("R1 re-reset", bus_rd_data, 32'h0004_0001);

        finish_run();
    end
endmodule